// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Cell Array

This block holds ten output cells behind a programmable AND-OR array, of the kind found in small programmable logic parts. Every product term is a masked AND over the true and complemented forms of twelve dedicated inputs and ten feedback signals. Each cell ORs its own group of terms. The group size depends on the cell's position: 8, 10, 12, 14, 16, 16, 14, 12, 10, 8. A cell can present its sum straight through or through a flip-flop, and it can invert it on the way out. Each cell also has its own enable term for the pin driver, and it returns a feedback signal to the array. One shared term presets every flip-flop at the next clock edge. A second shared term clears every flip-flop at once, with no clock.

The whole pattern is written before operation through a word-addressed port. Each address below 132 holds one product term. Address 132 holds the cell mode word. The bidirectional pins are split into a pad-side input `pinIn`, a driven value `pinOut` and an enable `pinOe`. System reset clears the flip-flops and the stored pattern.

Top module: `sopMacrocellArray`

## Requirements
- R1: While `rstN` is low, and right after it rises, every flip-flop is 0, every stored term is 0 and the mode word is 0, so `pinOe` and `pinOut` both read all zeros.
- R2: A term word is 45 bits. Bit 44 enables the term. Bit 2k selects signal k true and bit 2k+1 selects it complemented. Signals 0..11 are `inPins[11:0]` and signals 12..21 are the feedback of cells 0..9. An enabled term is 1 exactly when every selected literal is 1, so an enabled term with an empty mask reads 1.
- R3: A term whose bit 44 is 0 reads 0, whatever its mask holds.
- R4: Cell m owns 8,10,12,14,16,16,14,12,10,8 terms (m = 0..9). These sit at consecutive addresses starting at 0 for cell 0, so cell 4 uses 44..59 and cell 5 starts at 60. A cell's sum is the OR of its own terms only.
- R5: A combinational cell drives its sum on `pinOut` in the same cycle.
- R6: A registered cell drives its flip-flop, which loads the cell's sum at each rising clock edge.
- R7: Mode word bits 0..9 make cell m registered (1) or combinational (0). Bits 10..19 invert cell m's output on `pinOut`.
- R8: `pinOe[m]` equals the term at address 120+m.
- R9: A registered cell feeds back its flip-flop value, true polarity. A combinational cell feeds back its pad level `pinIn[m]`.
- R10: When the term at address 130 is 1 at a clock edge, every flip-flop loads 1.
- R11: While the term at address 131 is 1, every flip-flop is held at 0 at once, without waiting for a clock. This wins over R10.
- R12: A write to address 132 loads the mode word from data bits 19:0. A write to an address above 132 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the cell flip-flops and the pattern store |
| rstN | input | 1 | Active-low system reset |
| inPins | input | 12 | Dedicated array inputs |
| pinIn | input | 10 | Pad-side level of each bidirectional pin |
| pinOut | output | 10 | Value driven onto each bidirectional pin |
| pinOe | output | 10 | Driver enable for each bidirectional pin |
| cfgWe | input | 1 | Pattern write strobe |
| cfgAddr | input | 8 | Term address 0..131, or 132 for the mode word |
| cfgData | input | 45 | Term word or mode word |

## Verification
The bench builds the block with its default shape: twelve inputs, ten cells and eight terms at the narrowest position rising by two toward the middle. The uneven term groups are therefore present, and cells 4 and 5, both sixteen terms wide, sit next to each other. This brings the boundary between their address ranges within reach, together with a registered cell whose feedback toggles it. A behavioural model, rebuilt from the address rules, checks every cycle, including runs in which random term words are written while the inputs change at random.

// File: rtl/sopPkg.sv
package sopPkg;
  localparam int NUM_IN    = 12;
  localparam int NUM_MC    = 10;
  localparam int MIN_TERMS = 8;
  localparam int TERM_STEP = 2;
  localparam int NUM_SIG   = NUM_IN + NUM_MC;
  localparam int LIT_W     = 2 * NUM_SIG;
  localparam int TERM_W    = LIT_W + 1;
  localparam int MODE_W    = 2 * NUM_MC;

  function automatic int termCount(input int m);
    int d;
    d = (m < NUM_MC / 2) ? m : (NUM_MC - 1 - m);
    return MIN_TERMS + TERM_STEP * d;
  endfunction

  function automatic int termBase(input int m);
    int acc;
    acc = 0;
    for (int i = 0; i < m; i++) acc += termCount(i);
    return acc;
  endfunction

  localparam int SUM_TERMS   = termBase(NUM_MC);
  localparam int OE_BASE     = SUM_TERMS;
  localparam int PRESET_ADDR = OE_BASE + NUM_MC;
  localparam int ARST_ADDR   = PRESET_ADDR + 1;
  localparam int MODE_ADDR   = ARST_ADDR + 1;
  localparam int NUM_TERMS   = MODE_ADDR;
  localparam int ADDR_W      = $clog2(MODE_ADDR + 1);

  typedef struct packed {
    logic              termWe;
    logic              modeWe;
    logic [ADDR_W-1:0] idx;
  } cfgStrobe_t;
endpackage

// File: rtl/sopCfgCtrl.sv
module sopCfgCtrl
  import sopPkg::*;
(
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  output cfgStrobe_t        strobe
);
  always_comb begin
    strobe.termWe = cfgWe && (cfgAddr < ADDR_W'(NUM_TERMS));
    strobe.modeWe = cfgWe && (cfgAddr == ADDR_W'(MODE_ADDR));
    strobe.idx    = cfgAddr;
  end
endmodule

// File: rtl/sopDatapath.sv
module sopDatapath
  import sopPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] inPins,
  input  logic [NUM_MC-1:0] pinIn,
  input  logic [TERM_W-1:0] cfgData,
  input  cfgStrobe_t        strobe,
  output logic [NUM_MC-1:0] pinOut,
  output logic [NUM_MC-1:0] pinOe,
  output logic [NUM_MC-1:0] regQ,
  output logic [NUM_MC-1:0] sumVec,
  output logic [MODE_W-1:0] modeReg,
  output logic              presetHit,
  output logic              arstHit
);
  logic [TERM_W-1:0]    termMem [NUM_TERMS];
  logic [NUM_MC-1:0]    regSel;
  logic [NUM_MC-1:0]    lowSel;
  logic [NUM_MC-1:0]    fbVec;
  logic [NUM_SIG-1:0]   sigVec;
  logic [LIT_W-1:0]     lits;
  logic [NUM_TERMS-1:0] prod;
  logic [NUM_MC-1:0]    cellOut;
  logic                 clr;

  // pattern store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_TERMS; i++) termMem[i] <= '0;
    end else if (strobe.termWe) begin
      termMem[strobe.idx] <= cfgData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeReg <= '0;
    else if (strobe.modeWe) modeReg <= cfgData[MODE_W-1:0];
  end

  assign regSel = modeReg[NUM_MC-1:0];
  assign lowSel = modeReg[MODE_W-1:NUM_MC];

  // feedback: flip-flop when registered, pad when combinational
  assign fbVec  = (regSel & regQ) | (~regSel & pinIn);
  assign sigVec = {fbVec, inPins};

  for (genvar k = 0; k < NUM_SIG; k++) begin : gLit
    assign lits[2*k]   = sigVec[k];
    assign lits[2*k+1] = ~sigVec[k];
  end

  // every term: enabled and no selected literal low
  for (genvar t = 0; t < NUM_TERMS; t++) begin : gTerm
    assign prod[t] = termMem[t][TERM_W-1] & ~|(termMem[t][LIT_W-1:0] & ~lits);
  end

  for (genvar m = 0; m < NUM_MC; m++) begin : gCell
    localparam int B = termBase(m);
    localparam int C = termCount(m);
    assign sumVec[m] = |prod[B +: C];
    assign pinOe[m]  = prod[OE_BASE + m];
  end

  assign presetHit = prod[PRESET_ADDR];
  assign arstHit   = prod[ARST_ADDR];
  assign clr       = ~rstN | arstHit;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) regQ <= '0;
    else if (presetHit) regQ <= '1;
    else regQ <= sumVec;
  end

  assign cellOut = (regSel & regQ) | (~regSel & sumVec);
  assign pinOut  = cellOut ^ lowSel;
endmodule

// File: rtl/sopMacrocellArray.sv
module sopMacrocellArray
  import sopPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       inPins,
  input  logic [9:0]        pinIn,
  output logic [9:0]        pinOut,
  output logic [9:0]        pinOe,
  input  logic              cfgWe,
  input  logic [7:0]        cfgAddr,
  input  logic [44:0]       cfgData
);
  cfgStrobe_t        strobe;
  logic [NUM_MC-1:0] regQ;
  logic [NUM_MC-1:0] sumVec;
  logic [MODE_W-1:0] modeReg;
  logic              presetHit;
  logic              arstHit;

  sopCfgCtrl uCtrl (
    .cfgWe  (cfgWe),
    .cfgAddr(cfgAddr),
    .strobe (strobe)
  );

  sopDatapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .inPins   (inPins),
    .pinIn    (pinIn),
    .cfgData  (cfgData),
    .strobe   (strobe),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .regQ     (regQ),
    .sumVec   (sumVec),
    .modeReg  (modeReg),
    .presetHit(presetHit),
    .arstHit  (arstHit)
  );
endmodule

// File: rtl/sopMacrocellArray_chk.sv
module sopMacrocellArray_chk
  import sopPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [7:0]        cfgAddr,
  input logic [NUM_MC-1:0] pinOe,
  input logic [NUM_MC-1:0] regQ,
  input logic [NUM_MC-1:0] sumVec,
  input logic [MODE_W-1:0] modeReg,
  input logic              presetHit,
  input logic              arstHit
);
  AST_OE_CLEAR_AFTER_RESET: assert property (@(posedge clk) $rose(rstN) |-> pinOe == '0); // R1
  AST_SUM_CAPTURE: assert property (@(posedge clk) disable iff (!rstN || arstHit)
    (!presetHit && !arstHit) |=> regQ == $past(sumVec)); // R6
  AST_PRESET_ALL_HIGH: assert property (@(posedge clk) disable iff (!rstN || arstHit)
    (presetHit && !arstHit) |=> regQ == '1); // R10
  AST_ASYNC_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    arstHit |-> regQ == '0); // R11
  AST_MODE_WRITE_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWe || cfgAddr != 8'(MODE_ADDR)) |=> modeReg == $past(modeReg)); // R12
endmodule

bind sopMacrocellArray sopMacrocellArray_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWe    (cfgWe),
  .cfgAddr  (cfgAddr),
  .pinOe    (pinOe),
  .regQ     (regQ),
  .sumVec   (sumVec),
  .modeReg  (modeReg),
  .presetHit(presetHit),
  .arstHit  (arstHit)
);

// File: tb/sopMacrocellArray_test.sv
module sopMacrocellArray_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] inPins = '0;
  logic [9:0]  pinIn = '0;
  logic [9:0]  pinOut;
  logic [9:0]  pinOe;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [44:0] cfgData = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string curReq = "R1";

  // behavioural reference state
  logic [44:0] mTerm [0:131];
  logic [19:0] mMode = '0;
  logic [9:0]  mQ = '0;
  int tcnt [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
  int tbase [10];

  localparam logic [44:0] EN = 45'(1) << 44;

  always #5 clk = ~clk;

  sopMacrocellArray uut (
    .clk(clk), .rstN(rstN), .inPins(inPins), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData)
  );

  function automatic logic [44:0] lit(input int sig, input bit neg);
    return 45'(1) << (2 * sig + (neg ? 1 : 0));
  endfunction

  function automatic bit mSig(input int k);
    if (k < 12) return inPins[k];
    return mMode[k-12] ? mQ[k-12] : pinIn[k-12];
  endfunction

  function automatic bit mTermVal(input int t);
    if (!mTerm[t][44]) return 0;
    for (int k = 0; k < 22; k++) begin
      if (mTerm[t][2*k] && !mSig(k)) return 0;
      if (mTerm[t][2*k+1] && mSig(k)) return 0;
    end
    return 1;
  endfunction

  function automatic bit mSum(input int m);
    for (int j = 0; j < tcnt[m]; j++) if (mTermVal(tbase[m] + j)) return 1;
    return 0;
  endfunction

  function automatic logic [9:0] expOut();
    logic [9:0] r;
    for (int m = 0; m < 10; m++) r[m] = (mMode[m] ? mQ[m] : mSum(m)) ^ mMode[10+m];
    return r;
  endfunction

  function automatic logic [9:0] expOe();
    logic [9:0] r;
    for (int m = 0; m < 10; m++) r[m] = mTermVal(120 + m);
    return r;
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // model update at the clock edge
  always @(posedge clk) begin
    logic [9:0] nq;
    if (!rstN) begin
      for (int i = 0; i < 132; i++) mTerm[i] = '0;
      mMode = '0;
      mQ = '0;
    end else begin
      if (mTermVal(131)) nq = '0;
      else if (mTermVal(130)) nq = '1;
      else for (int m = 0; m < 10; m++) nq[m] = mSum(m);
      if (cfgWe && cfgAddr < 8'd132) mTerm[cfgAddr] = cfgData;
      if (cfgWe && cfgAddr == 8'd132) mMode = cfgData[19:0];
      mQ = nq;
    end
  end

  // every-cycle comparison, 3 ns after the input drive point
  always begin
    @(negedge clk);
    #3;
    if (rstN && !done) begin
      if (mTermVal(131)) mQ = '0;
      check(curReq, pinOut, expOut());
      check("R8", pinOe, expOe());
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int addr, input logic [44:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 8'(addr); cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [9:0] prev;
    for (int m = 0; m < 10; m++) tbase[m] = (m == 0) ? 0 : tbase[m-1] + tcnt[m-1];
    for (int i = 0; i < 132; i++) mTerm[i] = '0;
    cycles(3);
    rstN = 1'b1;
    #3;
    check("R1", pinOut, 10'b0);
    check("R1", pinOe, 10'b0);

    // R2 / R5 / R8: cell 0 term = in0 & ~in1, cell 0 driver always on
    curReq = "R2";
    wr(0, EN | lit(0, 0) | lit(1, 1));
    wr(120, EN);
    for (int v = 0; v < 4; v++) begin
      @(negedge clk); inPins[0] = v[0]; inPins[1] = v[1];
      #2;
      check("R2", {9'b0, pinOut[0]}, {9'b0, v[0] & ~v[1]});
      check("R5", {9'b0, pinOut[0]}, {9'b0, v[0] & ~v[1]});
      check("R8", {9'b0, pinOe[0]}, 10'b1);
    end

    // R3: disabled term with a live mask adds nothing
    curReq = "R3";
    wr(1, lit(2, 0));
    @(negedge clk); inPins[0] = 0; inPins[2] = 1;
    #2 check("R3", {9'b0, pinOut[0]}, 10'b0);

    // R4: last term of cell 4 and first of cell 5
    curReq = "R4";
    wr(59, EN | lit(5, 0));
    wr(60, EN | lit(6, 0));
    @(negedge clk); inPins[5] = 1; inPins[6] = 0;
    #2 check("R4", {8'b0, pinOut[5:4]}, 10'b01);
    @(negedge clk); inPins[5] = 0; inPins[6] = 1;
    #2 check("R4", {8'b0, pinOut[5:4]}, 10'b10);

    // R7: cell 4 inverted, cells 1 and 7 registered
    curReq = "R7";
    wr(132, 45'((1 << 14) | (1 << 1) | (1 << 7)));
    #2 check("R7", {9'b0, pinOut[4]}, 10'b1);

    // R9: cell 2 uses complemented pad level of combinational cell 3
    curReq = "R9";
    wr(18, EN | lit(15, 1));
    @(negedge clk); pinIn[3] = 0;
    #2 check("R9", {9'b0, pinOut[2]}, 10'b1);
    @(negedge clk); pinIn[3] = 1;
    #2 check("R9", {9'b0, pinOut[2]}, 10'b0);

    // R6 / R9: cell 1 loads its own complemented flip-flop, so it toggles
    curReq = "R6";
    wr(8, EN | lit(13, 1));
    for (int i = 0; i < 4; i++) begin
      #2 prev = pinOut;
      @(negedge clk);
      #2 check("R6", {9'b0, pinOut[1]}, {9'b0, ~prev[1]});
    end

    // R10: shared preset on in3
    curReq = "R10";
    wr(130, EN | lit(3, 0));
    @(negedge clk); inPins[3] = 1;
    @(negedge clk);
    #2 check("R10", {9'b0, pinOut[7]}, 10'b1);

    // R11: shared clear on in4, no clock edge between drive and check
    curReq = "R11";
    wr(131, EN | lit(4, 0));
    @(negedge clk); inPins[4] = 1;
    #2 check("R11", {8'b0, pinOut[7], pinOut[1]}, 10'b0);
    @(negedge clk);
    #2 check("R11", {8'b0, pinOut[7], pinOut[1]}, 10'b0);
    @(negedge clk); inPins[4] = 0; inPins[3] = 0;

    // R12: write above the mode address is ignored
    curReq = "R12";
    wr(140, '1);
    #2;
    check("R12", {9'b0, pinOe[9]}, 10'b0);
    check("R12", {9'b0, pinOut[4]}, {9'b0, ~(inPins[5])});
    cycles(2);

    // random inputs and random term words
    curReq = "R2";
    for (int i = 0; i < 400; i++) begin
      if (i % 16 == 5) wr($urandom_range(0, 129),
                          {1'b1, 44'($urandom) & 44'($urandom) & {12'b0, 32'($urandom)}});
      @(negedge clk);
      inPins = 12'($urandom);
      inPins[4] = 0;
      pinIn = 10'($urandom);
    end
    cycles(2);
    finishRun();
  end
endmodule